// File: doc/BRIEF.md
# Volatile Battery-Backed Key Store

This block holds a 256-bit secret key in volatile storage that survives as long as at least one of two supplies, main or backup battery, is present. The key can be written only through a serial test-port path. Any contact with the store from that path first wipes both the key and the configuration memory. Only then is a load allowed.

A test-port mode request, read attempt or bit strobe that arrives while the store is idle starts a wipe. For one cycle the block zeroes the key and pulses a global configuration-wipe output. If the mode request is still held after that cycle, the block grants access and takes serial bits, first bit into the most significant position. When the request drops, the key becomes valid if all 256 bits arrived. Otherwise the key is zeroed. The key leaves the block only on an internal port to the decryptor, and that port reads zero while the key is invalid. No path reads it back. User logic may ask for a clear, and that request is honoured only when the running image was encrypted. Device resets and reloads leave the key untouched.

Top module: `bbkey_vault`

## Requirements
- R1: `key_out` carries the stored key while `key_valid` is 1, with the first accepted bit at bit 255 and the 256th at bit 0. While `key_valid` is 0, `key_out` is all zeros.
- R2: `key_valid` rises only on the edge at which the mode request drops with exactly 256 bits accepted. Bit strobes after the 256th are ignored.
- R3: While idle and out of reset, a sampled `tp_mode_req`, `tp_rd_req` or `tp_bit_vld` zeroes the key and clears `key_valid` at that edge. A read attempt never places key data on any output.
- R4: `cfg_wipe` is high for exactly the one cycle after the triggering edge, and low otherwise.
- R5: `access_granted` rises the cycle after the `cfg_wipe` pulse, and only if `tp_mode_req` is still high. Bit strobes seen during the wipe cycle are not loaded.
- R6: If the mode request drops with fewer than 256 bits accepted, the block returns to idle with the key zeroed and `key_valid` at 0.
- R7: The key and `key_valid` are kept while `pwr_main` or `pwr_batt` is 1. At any edge where both are 0, the key is zeroed, `key_valid` is cleared and any access is aborted.
- R8: `fab_zero_req` zeroes the key and clears `key_valid` at the next edge only when `cfg_enc_img` is 1. With `cfg_enc_img` at 0 it has no effect.
- R9: Holding `rst_n` low, as a device reset or reload does, changes neither `key_valid` nor `key_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Device reset, active low; resets the access sequencer only |
| pwr_main | input | 1 | Main supply present |
| pwr_batt | input | 1 | Backup battery present |
| tp_mode_req | input | 1 | Test-port request to hold key-access mode |
| tp_rd_req | input | 1 | Test-port read attempt on the key store |
| tp_bit_vld | input | 1 | Serial key bit strobe |
| tp_bit | input | 1 | Serial key bit value |
| fab_zero_req | input | 1 | Clear request from user logic |
| cfg_enc_img | input | 1 | Device was configured with an encrypted image |
| cfg_wipe | output | 1 | One-cycle global configuration-memory wipe |
| access_granted | output | 1 | Key-access mode active, bits are accepted |
| key_valid | output | 1 | Stored key is complete and usable |
| key_out | output | 256 | Key to the decryptor, zero while invalid |

## Verification
The bench goes after loads of the wrong length. With 100 bits, a design that commits anyway would show a partial key as valid. With 300 bits, a design that keeps shifting would show the last 256 bits instead of the first 256. It also strobes bits during the wipe cycle, which a design that opens access one cycle early would load, and it sends a bare read attempt, which must wipe the key and pulse the wipe output without opening access. Supply loss is tested on one rail and then on both, and the fabric clear is tested with and without an encrypted image. A design that tied retention to one supply, or honoured the clear unconditionally, would lose the key where it must survive. Reset pulses on a valid key catch a store that was wrongly placed on the device reset.

// File: rtl/bbkey_pkg.sv
package bbkey_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WIPE   = 2'd1,
        ST_ACCESS = 2'd2
    } seq_st_e;

endpackage

// File: rtl/bbkey_seq.sv
module bbkey_seq
    import bbkey_pkg::*;
#(
    parameter int KEY_W = 256,
    localparam int CNT_W = $clog2(KEY_W + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic mode_req,
    input  logic rd_req,
    input  logic bit_vld,
    input  logic zero_req,
    output logic begin_wipe,
    output logic shift_en,
    output logic commit,
    output logic abort,
    output logic in_wipe,
    output logic in_access
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(KEY_W);

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        begin_wipe = 1'b0;
        shift_en   = 1'b0;
        commit     = 1'b0;
        abort      = 1'b0;
        if (!pwr_ok) begin
            seq_d.st  = ST_IDLE;
            seq_d.cnt = '0;
        end else if (rst_n) begin
            unique case (seq_q.st)
                ST_IDLE: begin
                    if (mode_req || rd_req || bit_vld) begin
                        seq_d.st   = ST_WIPE;
                        begin_wipe = 1'b1;
                    end
                end
                ST_WIPE: begin
                    seq_d.st  = mode_req ? ST_ACCESS : ST_IDLE;
                    seq_d.cnt = '0;
                end
                ST_ACCESS: begin
                    if (!mode_req) begin
                        seq_d.st = ST_IDLE;
                        if (seq_q.cnt == FULL) begin
                            commit = 1'b1;
                        end else begin
                            abort = 1'b1;
                        end
                    end else if (bit_vld && seq_q.cnt != FULL) begin
                        shift_en  = 1'b1;
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
                default: seq_d.st = ST_IDLE;
            endcase
            if (zero_req) begin
                seq_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign in_wipe   = (seq_q.st == ST_WIPE);
    assign in_access = (seq_q.st == ST_ACCESS);

endmodule

// File: rtl/bbkey_store.sv
module bbkey_store #(
    parameter int KEY_W = 256
) (
    input  logic             clk,
    input  logic             pwr_ok,
    input  logic             zero_req,
    input  logic             begin_wipe,
    input  logic             abort,
    input  logic             shift_en,
    input  logic             shift_bit,
    input  logic             commit,
    output logic [KEY_W-1:0] key,
    output logic             valid
);

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic             valid;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pwr_ok || zero_req || begin_wipe || abort) begin
            st_d.key   = '0;
            st_d.valid = 1'b0;
        end else if (shift_en) begin
            st_d.key = {st_q.key[KEY_W-2:0], shift_bit};
        end else if (commit) begin
            st_d.valid = 1'b1;
        end
    end

    // Retention domain: cleared only by supply loss or explicit wipes, never by reset.
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign key   = st_q.key;
    assign valid = st_q.valid;

endmodule

// File: rtl/bbkey_vault.sv
module bbkey_vault #(
    parameter int KEY_W = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_main,
    input  logic             pwr_batt,
    input  logic             tp_mode_req,
    input  logic             tp_rd_req,
    input  logic             tp_bit_vld,
    input  logic             tp_bit,
    input  logic             fab_zero_req,
    input  logic             cfg_enc_img,
    output logic             cfg_wipe,
    output logic             access_granted,
    output logic             key_valid,
    output logic [KEY_W-1:0] key_out
);

    logic             pwr_ok;
    logic             zero_ok;
    logic             begin_wipe;
    logic             shift_en;
    logic             commit;
    logic             abort;
    logic [KEY_W-1:0] key_raw;

    assign pwr_ok  = pwr_main | pwr_batt;
    assign zero_ok = fab_zero_req & cfg_enc_img;

    bbkey_seq #(.KEY_W(KEY_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_ok     (pwr_ok),
        .mode_req   (tp_mode_req),
        .rd_req     (tp_rd_req),
        .bit_vld    (tp_bit_vld),
        .zero_req   (zero_ok),
        .begin_wipe (begin_wipe),
        .shift_en   (shift_en),
        .commit     (commit),
        .abort      (abort),
        .in_wipe    (cfg_wipe),
        .in_access  (access_granted)
    );

    bbkey_store #(.KEY_W(KEY_W)) u_store (
        .clk        (clk),
        .pwr_ok     (pwr_ok),
        .zero_req   (zero_ok),
        .begin_wipe (begin_wipe),
        .abort      (abort),
        .shift_en   (shift_en),
        .shift_bit  (tp_bit),
        .commit     (commit),
        .key        (key_raw),
        .valid      (key_valid)
    );

    assign key_out = key_valid ? key_raw : '0;

endmodule

// File: rtl/bbkey_vault_chk.sv
module bbkey_vault_chk #(
    parameter int KEY_W = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_main,
    input logic             pwr_batt,
    input logic             fab_zero_req,
    input logic             cfg_enc_img,
    input logic             cfg_wipe,
    input logic             access_granted,
    input logic             key_valid,
    input logic [KEY_W-1:0] key_out
);

    // R1
    masked_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |-> key_out == '0);

    // R2
    commit_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_valid) |-> $past(access_granted) && !access_granted);

    // R3
    wipe_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wipe |-> !key_valid && !access_granted);

    // R4
    wipe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wipe |=> !cfg_wipe);

    // R5
    grant_after_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_granted) |-> $past(cfg_wipe));

    // R7
    power_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_main || pwr_batt) |=> !key_valid && !access_granted);

    // R8
    fabric_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fab_zero_req && cfg_enc_img) |=> !key_valid);

endmodule

bind bbkey_vault bbkey_vault_chk #(.KEY_W(KEY_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pwr_main       (pwr_main),
    .pwr_batt       (pwr_batt),
    .fab_zero_req   (fab_zero_req),
    .cfg_enc_img    (cfg_enc_img),
    .cfg_wipe       (cfg_wipe),
    .access_granted (access_granted),
    .key_valid      (key_valid),
    .key_out        (key_out)
);

// File: tb/bbkey_vault_test.sv
module bbkey_vault_test;

    localparam int KW = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_main = 1'b0;
    logic          pwr_batt = 1'b0;
    logic          tp_mode_req = 1'b0;
    logic          tp_rd_req = 1'b0;
    logic          tp_bit_vld = 1'b0;
    logic          tp_bit = 1'b0;
    logic          fab_zero_req = 1'b0;
    logic          cfg_enc_img = 1'b0;
    logic          cfg_wipe;
    logic          access_granted;
    logic          key_valid;
    logic [KW-1:0] key_out;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    bbkey_vault #(.KEY_W(KW)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .pwr_main       (pwr_main),
        .pwr_batt       (pwr_batt),
        .tp_mode_req    (tp_mode_req),
        .tp_rd_req      (tp_rd_req),
        .tp_bit_vld     (tp_bit_vld),
        .tp_bit         (tp_bit),
        .fab_zero_req   (fab_zero_req),
        .cfg_enc_img    (cfg_enc_img),
        .cfg_wipe       (cfg_wipe),
        .access_granted (access_granted),
        .key_valid      (key_valid),
        .key_out        (key_out)
    );

    // Behavioural reference: phase 0 idle, 1 wiping, 2 loading.
    int          m_phase = 0;
    int          m_count = 0;
    logic [KW-1:0] m_key = '0;
    logic        m_valid = 1'b0;

    always @(posedge clk) begin
        if (!(pwr_main || pwr_batt)) begin
            m_key = '0; m_valid = 1'b0; m_count = 0; m_phase = 0;
        end else begin
            if (!rst_n) begin
                m_phase = 0; m_count = 0;
            end else if (m_phase == 0) begin
                if (tp_mode_req || tp_rd_req || tp_bit_vld) begin
                    m_phase = 1; m_key = '0; m_valid = 1'b0;
                end
            end else if (m_phase == 1) begin
                m_phase = tp_mode_req ? 2 : 0;
                m_count = 0;
            end else begin
                if (!tp_mode_req) begin
                    if (m_count == KW) m_valid = 1'b1;
                    else m_key = '0;
                    m_phase = 0;
                end else if (tp_bit_vld && m_count < KW) begin
                    m_key = {m_key[KW-2:0], tp_bit};
                    m_count = m_count + 1;
                end
            end
            if (fab_zero_req && cfg_enc_img) begin
                m_key = '0; m_valid = 1'b0; m_count = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [KW-1:0] act, input logic [KW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        chk("R2 key_valid", KW'(key_valid), KW'(m_valid));
        chk("R1 key_out", key_out, m_valid ? m_key : '0);
        chk("R4 cfg_wipe", KW'(cfg_wipe), KW'(m_phase == 1));
        chk("R5 access_granted", KW'(access_granted), KW'(m_phase == 2));
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Holds mode, strobes a junk bit during the wipe cycle, then shifts nbits.
    task automatic load_key(input logic [KW-1:0] k, input int nbits);
        tp_mode_req = 1'b1;
        tick();
        tp_bit_vld = 1'b1; tp_bit = 1'b1;
        tick();
        for (int i = 0; i < nbits; i++) begin
            tp_bit_vld = 1'b1;
            tp_bit = (i < KW) ? k[KW-1-i] : i[0];
            tick();
        end
        tp_bit_vld = 1'b0;
        tp_mode_req = 1'b0;
        tick(2);
    endtask

    logic [KW-1:0] k1, k2;

    initial begin
        for (int i = 0; i < KW/32; i++) begin
            k1[i*32 +: 32] = 32'h9E3779B9 * (i + 3);
            k2[i*32 +: 32] = 32'h7F4A7C15 ^ (32'h01010101 * (i + 1));
        end
        tick(3);
        pwr_main = 1'b1; pwr_batt = 1'b1;
        tick(2);
        rst_n = 1'b1;
        tick(2);
        chk("R2 reset state invalid", KW'(key_valid), '0);
        chk("R1 reset key zero", key_out, '0);

        load_key(k1, KW);
        chk("R2 full load valid", KW'(key_valid), KW'(1));
        chk("R1 full load key", key_out, k1);

        // R9: device reset leaves the key alone
        rst_n = 1'b0; tick(3); rst_n = 1'b1; tick();
        chk("R9 reset keeps valid", KW'(key_valid), KW'(1));
        chk("R9 reset keeps key", key_out, k1);

        // R7: either supply alone retains
        pwr_main = 1'b0; tick(4);
        chk("R7 battery retains", key_out, k1);
        pwr_main = 1'b1; pwr_batt = 1'b0; tick(4);
        chk("R7 main retains", key_out, k1);
        pwr_main = 1'b0; tick();
        chk("R7 both absent clears", KW'(key_valid), '0);
        pwr_main = 1'b1; pwr_batt = 1'b1; tick();

        load_key(k2, KW);
        chk("R1 second key", key_out, k2);

        // R8: fabric clear needs an encrypted image
        fab_zero_req = 1'b1; cfg_enc_img = 1'b0; tick(); fab_zero_req = 1'b0; tick();
        chk("R8 plain image ignores clear", key_out, k2);
        fab_zero_req = 1'b1; cfg_enc_img = 1'b1; tick(); fab_zero_req = 1'b0; tick();
        chk("R8 encrypted image clears", KW'(key_valid), '0);
        cfg_enc_img = 1'b0;

        load_key(k1, KW);
        // R3: bare read attempt wipes, pulses once, grants nothing
        tp_rd_req = 1'b1; tick(); tp_rd_req = 1'b0;
        chk("R4 wipe pulse high", KW'(cfg_wipe), KW'(1));
        chk("R3 read wipes key", KW'(key_valid), '0);
        tick();
        chk("R4 wipe pulse ends", KW'(cfg_wipe), '0);
        chk("R5 no grant without mode", KW'(access_granted), '0);
        chk("R3 no data after read", key_out, '0);

        // R6: partial load
        load_key(k2, 100);
        chk("R6 partial invalid", KW'(key_valid), '0);
        chk("R6 partial zero", key_out, '0);

        // R2: overlong load keeps the first 256 bits
        load_key(k2, 300);
        chk("R2 overlong valid", KW'(key_valid), KW'(1));
        chk("R2 overlong key", key_out, k2);

        tick(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule